// File: doc/BRIEF.md
# I2C Transmit Status Flags with Burst Byte Loader

This block sits next to an I2C byte shifter on the transmit side. After every byte the shifter sends, it updates three status flags: transmit-buffer-empty, interrupt-pending and load-request. An acknowledge-check enable selects whether the acknowledge bit from the receiver affects which flags are set. When the check is on and the receiver does not acknowledge (the acknowledge bit is 1), only the interrupt-pending flag is raised. The automatic transfer path then stays idle and the CPU takes over.

A small burst loader inside the block reacts to the load-request flag. The CPU writes a byte count, which also rewinds the source address to zero. Each time the load-request flag is seen while the count is non-zero, the loader does four things. It reads the next byte from a local source buffer and places it in the transmit data register. It pulses a load strobe to the shifter. It clears all three flags and decrements the count. Because the flags are cleared in the cycle after they are raised, and the interrupt output is masked in that cycle, the CPU sees no interrupt during a burst. When the count reaches zero, the next byte-end leaves the flags set, so the CPU receives an end-of-burst interrupt.

Top module: `i2c_tx_autoload`

## Requirements
- R1: With `ack_chk_en`=0, a `byte_done` pulse sets all three flags in the following cycle, whatever the value of `ack_bit`.
- R2: With `ack_chk_en`=1 and `ack_bit`=0 (acknowledged), a `byte_done` pulse sets all three flags in the following cycle.
- R3: With `ack_chk_en`=1 and `ack_bit`=1 (not acknowledged), a `byte_done` pulse sets only `flag_irq`. In that case the loader does not start, `tx_load` stays low and `cnt_left` is unchanged.
- R4: When `flag_req` is 1, `cnt_left` is non-zero and `cnt_wr` is low, the next cycle shows `tx_load` high for exactly one cycle. In that cycle `tx_data` holds the source byte at the current address. Addresses start at 0 after a count load and advance by one per transfer.
- R5: Each loader transfer clears `flag_empty`, `flag_irq` and `flag_req` and decrements `cnt_left` by one.
- R6: `irq` equals `flag_irq` AND `irq_en`, except that `irq` is 0 in any cycle in which the loader services a request. As a result, no interrupt appears during a burst.
- R7: When `cnt_left` is 0, a byte-end leaves the flags set and the loader stays idle, so `irq` is asserted as the end-of-burst interrupt.
- R8: A pulse on `clr_empty`, `clr_irq` or `clr_req` clears only its own flag. If a flag is set and cleared in the same cycle, it ends up set.
- R9: After reset, all flags, `irq`, `tx_load`, `tx_data` and `cnt_left` are 0.
- R10: With `irq_en`=0, `irq` stays low even while `flag_irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_chk_en | input | 1 | Acknowledge-check enable |
| irq_en | input | 1 | Interrupt enable |
| byte_done | input | 1 | One-cycle pulse from the shifter at the end of a transmitted byte |
| ack_bit | input | 1 | Acknowledge bit received with that byte (0 = acknowledged) |
| clr_empty | input | 1 | CPU clear strobe for the buffer-empty flag |
| clr_irq | input | 1 | CPU clear strobe for the interrupt-pending flag |
| clr_req | input | 1 | CPU clear strobe for the load-request flag |
| cnt_wr | input | 1 | Loads the burst byte count and rewinds the source address |
| cnt_wdata | input | 8 | Burst byte count |
| src_we | input | 1 | Source buffer write enable |
| src_waddr | input | 4 | Source buffer write address |
| src_wdata | input | 8 | Source buffer write data |
| tx_data | output | 8 | Transmit data register |
| tx_load | output | 1 | One-cycle strobe telling the shifter to take `tx_data` |
| flag_empty | output | 1 | Transmit-buffer-empty flag |
| flag_irq | output | 1 | Interrupt-pending flag |
| flag_req | output | 1 | Load-request flag |
| irq | output | 1 | Interrupt output |
| cnt_left | output | 8 | Bytes remaining in the burst |

## Verification
The hardest situation to reach is a not-acknowledged byte in the middle of a running burst. The bench programs the source buffer, loads a count of four and lets one acknowledged byte trigger a transfer. It then ends a byte with `ack_bit`=1 while the check is enabled. At that point it confirms four things: only the interrupt flag is raised, the interrupt reaches `irq`, the loader stays idle and the count is unchanged. After clearing the interrupt flag, the bench ends another acknowledged byte and checks that the burst resumes at the second source address. It does the same for the end-of-burst case, first running a full burst of three transfers and then checking that the byte ending at count zero leaves every flag set.

// File: rtl/i2c_txf_pkg.sv
package i2c_txf_pkg;

    typedef struct packed {
        logic empty;
        logic irq;
        logic req;
    } txf_flags_t;

endpackage

// File: rtl/txf_srcmem.sv
module txf_srcmem #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/txf_flags.sv
module txf_flags
    import i2c_txf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_done,
    input  logic       ack_bit,
    input  logic       ack_chk_en,
    input  logic       clr_empty,
    input  logic       clr_irq,
    input  logic       clr_req,
    input  logic       svc_clr,
    output txf_flags_t flags_q
);

    txf_flags_t flags_d;
    logic       set_all;
    logic       set_irq;

    always_comb begin
        set_all = byte_done && (!ack_chk_en || !ack_bit);
        set_irq = byte_done;
        flags_d = flags_q;
        // clears first, sets afterwards so a set wins
        if (clr_empty || svc_clr) flags_d.empty = 1'b0;
        if (clr_irq   || svc_clr) flags_d.irq   = 1'b0;
        if (clr_req   || svc_clr) flags_d.req   = 1'b0;
        if (set_all) begin
            flags_d.empty = 1'b1;
            flags_d.req   = 1'b1;
        end
        if (set_irq) flags_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assert_set_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !ack_chk_en) |=> (flags_q.empty && flags_q.irq && flags_q.req));

    assert_ack_set_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && ack_chk_en && !ack_bit) |=> (flags_q.empty && flags_q.irq && flags_q.req));

    assert_nack_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && ack_chk_en && ack_bit) |=> flags_q.irq);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !byte_done) |=> !flags_q.req);

endmodule

// File: rtl/txf_engine.sv
module txf_engine #(
    parameter int CNT_W = 8,
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_flag,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [DW-1:0]    rd_data,
    output logic [AW-1:0]    rd_addr,
    output logic             svc,
    output logic [DW-1:0]    tx_data,
    output logic             tx_load,
    output logic [CNT_W-1:0] cnt_left
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic             load;
    } eng_t;

    eng_t eng_d;
    eng_t eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.load = 1'b0;
        svc        = req_flag && (eng_q.cnt != '0) && !cnt_wr;
        if (cnt_wr) begin
            eng_d.cnt  = cnt_wdata;
            eng_d.addr = '0;
        end else if (svc) begin
            eng_d.cnt  = eng_q.cnt - 1'b1;
            eng_d.addr = eng_q.addr + 1'b1;
            eng_d.data = rd_data;
            eng_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign rd_addr  = eng_q.addr;
    assign tx_data  = eng_q.data;
    assign tx_load  = eng_q.load;
    assign cnt_left = eng_q.cnt;

    assert_load_after_svc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> tx_load);

    assert_load_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load || $past(svc));

    assert_cnt_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> (cnt_left == $past(cnt_left) - 1'b1));

    assert_stop_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_left == '0 && !cnt_wr) |=> !tx_load);

endmodule

// File: rtl/i2c_tx_autoload.sv
module i2c_tx_autoload
    import i2c_txf_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DW        = 8,
    parameter int SRC_DEPTH = 16,
    localparam int AW       = $clog2(SRC_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_chk_en,
    input  logic             irq_en,
    input  logic             byte_done,
    input  logic             ack_bit,
    input  logic             clr_empty,
    input  logic             clr_irq,
    input  logic             clr_req,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             src_we,
    input  logic [AW-1:0]    src_waddr,
    input  logic [DW-1:0]    src_wdata,
    output logic [DW-1:0]    tx_data,
    output logic             tx_load,
    output logic             flag_empty,
    output logic             flag_irq,
    output logic             flag_req,
    output logic             irq,
    output logic [CNT_W-1:0] cnt_left
);

    txf_flags_t    flags_q;
    logic          svc;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;

    txf_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_done  (byte_done),
        .ack_bit    (ack_bit),
        .ack_chk_en (ack_chk_en),
        .clr_empty  (clr_empty),
        .clr_irq    (clr_irq),
        .clr_req    (clr_req),
        .svc_clr    (svc),
        .flags_q    (flags_q)
    );

    txf_srcmem #(.DEPTH(SRC_DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (src_we),
        .waddr (src_waddr),
        .wdata (src_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    txf_engine #(.CNT_W(CNT_W), .DW(DW), .DEPTH(SRC_DEPTH)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_flag  (flags_q.req),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .svc       (svc),
        .tx_data   (tx_data),
        .tx_load   (tx_load),
        .cnt_left  (cnt_left)
    );

    assign flag_empty = flags_q.empty;
    assign flag_irq   = flags_q.irq;
    assign flag_req   = flags_q.req;
    assign irq        = flags_q.irq && irq_en && !svc;

    assert_no_irq_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_req && cnt_left != '0 && !cnt_wr) |-> !irq);

    assert_load_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !$past(byte_done)) |-> (!flag_req && !flag_empty));

    assert_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && flag_irq));

endmodule

// File: tb/sim_i2c_tx_autoload.sv
module sim_i2c_tx_autoload;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack_chk_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       byte_done = 1'b0;
    logic       ack_bit = 1'b0;
    logic       clr_empty = 1'b0;
    logic       clr_irq = 1'b0;
    logic       clr_req = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       src_we = 1'b0;
    logic [3:0] src_waddr = '0;
    logic [7:0] src_wdata = '0;
    logic [7:0] tx_data;
    logic       tx_load;
    logic       flag_empty;
    logic       flag_irq;
    logic       flag_req;
    logic       irq;
    logic [7:0] cnt_left;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    i2c_tx_autoload u0 (
        .clk(clk), .rst_n(rst_n), .ack_chk_en(ack_chk_en), .irq_en(irq_en),
        .byte_done(byte_done), .ack_bit(ack_bit), .clr_empty(clr_empty),
        .clr_irq(clr_irq), .clr_req(clr_req), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .src_we(src_we), .src_waddr(src_waddr), .src_wdata(src_wdata),
        .tx_data(tx_data), .tx_load(tx_load), .flag_empty(flag_empty),
        .flag_irq(flag_irq), .flag_req(flag_req), .irq(irq), .cnt_left(cnt_left)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] src_byte(input int i);
        return 8'h3C ^ 8'(i * 8'h11);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input int e, input int i, input int r);
        chk(req, "flag_empty", int'(flag_empty), e);
        chk(req, "flag_irq", int'(flag_irq), i);
        chk(req, "flag_req", int'(flag_req), r);
    endtask

    // sampled 1 time unit after the negedge that follows the registering edge
    task automatic byte_end(input logic ack);
        @(negedge clk);
        byte_done = 1'b1;
        ack_bit   = ack;
        @(negedge clk);
        byte_done = 1'b0;
        ack_bit   = 1'b0;
        #1;
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_empty = 1'b1; clr_irq = 1'b1; clr_req = 1'b1;
        @(negedge clk);
        clr_empty = 1'b0; clr_irq = 1'b0; clr_req = 1'b0;
        #1;
    endtask

    task automatic load_cnt(input logic [7:0] n);
        @(negedge clk);
        cnt_wr = 1'b1; cnt_wdata = n;
        @(negedge clk);
        cnt_wr = 1'b0;
        #1;
    endtask

    task automatic fill_src();
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            src_we = 1'b1; src_waddr = 4'(a); src_wdata = src_byte(a);
        end
        @(negedge clk);
        src_we = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk_flags("R9", 0, 0, 0);
        chk("R9", "irq", int'(irq), 0);
        chk("R9", "tx_load", int'(tx_load), 0);
        chk("R9", "tx_data", int'(tx_data), 0);
        chk("R9", "cnt_left", int'(cnt_left), 0);
    endtask

    task automatic t_nocheck();
        ack_chk_en = 1'b0; irq_en = 1'b1;
        byte_end(1'b1);
        chk_flags("R1", 1, 1, 1);
        chk("R7", "irq at zero count", int'(irq), 1);
        clear_all();
        byte_end(1'b0);
        chk_flags("R1", 1, 1, 1);
        clear_all();
        chk_flags("R8", 0, 0, 0);
    endtask

    task automatic t_ack_masked();
        ack_chk_en = 1'b1; irq_en = 1'b0;
        byte_end(1'b0);
        chk_flags("R2", 1, 1, 1);
        chk("R10", "irq masked", int'(irq), 0);
        irq_en = 1'b1;
        #1;
        chk("R6", "irq enabled", int'(irq), 1);
        clear_all();
    endtask

    task automatic t_nack();
        ack_chk_en = 1'b1; irq_en = 1'b1;
        byte_end(1'b1);
        chk_flags("R3", 0, 1, 0);
        chk("R3", "irq on nack", int'(irq), 1);
        @(negedge clk); #1;
        chk("R3", "no load", int'(tx_load), 0);
        clear_all();
    endtask

    task automatic t_set_wins();
        ack_chk_en = 1'b0;
        @(negedge clk);
        byte_done = 1'b1; ack_bit = 1'b0; clr_irq = 1'b1; clr_req = 1'b1;
        @(negedge clk);
        byte_done = 1'b0; clr_irq = 1'b0; clr_req = 1'b0;
        #1;
        chk_flags("R8", 1, 1, 1);
        @(negedge clk);
        clr_empty = 1'b1;
        @(negedge clk);
        clr_empty = 1'b0;
        #1;
        chk_flags("R8", 0, 1, 1);
        clear_all();
    endtask

    task automatic t_burst();
        ack_chk_en = 1'b1; irq_en = 1'b1;
        load_cnt(8'd3);
        for (int i = 0; i < 3; i++) begin
            byte_end(1'b0);
            chk("R6", "irq during service", int'(irq), 0);
            chk("R4", "flag_req before load", int'(flag_req), 1);
            @(negedge clk); #1;
            chk("R4", "tx_load", int'(tx_load), 1);
            chk("R4", "tx_data", int'(tx_data), int'(src_byte(i)));
            chk_flags("R5", 0, 0, 0);
            chk("R5", "cnt_left", int'(cnt_left), 2 - i);
            @(negedge clk); #1;
            chk("R4", "tx_load single", int'(tx_load), 0);
        end
        byte_end(1'b0);
        chk_flags("R7", 1, 1, 1);
        chk("R7", "end irq", int'(irq), 1);
        @(negedge clk); #1;
        chk("R7", "no load at zero", int'(tx_load), 0);
        chk("R7", "flag_req held", int'(flag_req), 1);
        clear_all();
    endtask

    task automatic t_nack_mid();
        ack_chk_en = 1'b1; irq_en = 1'b1;
        load_cnt(8'd4);
        byte_end(1'b0);
        @(negedge clk); #1;
        chk("R4", "first tx_data", int'(tx_data), int'(src_byte(0)));
        byte_end(1'b1);
        chk_flags("R3", 0, 1, 0);
        chk("R3", "irq mid nack", int'(irq), 1);
        @(negedge clk); #1;
        chk("R3", "no load mid", int'(tx_load), 0);
        chk("R3", "cnt kept", int'(cnt_left), 3);
        clear_all();
        byte_end(1'b0);
        @(negedge clk); #1;
        chk("R4", "resume load", int'(tx_load), 1);
        chk("R4", "resume data", int'(tx_data), int'(src_byte(1)));
        chk("R5", "resume cnt", int'(cnt_left), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        fill_src();
        t_nocheck();
        t_ack_masked();
        t_nack();
        t_set_wins();
        t_burst();
        t_nack_mid();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule